// File: doc/BRIEF.md
# Paged Nonvolatile Array Write Controller

This block fronts a 2048-byte nonvolatile data array that is split into 32 rows of 64 bytes. A CPU sees the array in its data address space (000h to 7FFh) only while the map bit of a small control register is set. Reads of a mapped address return array contents. Writes never touch the array directly. Each write fills a per-column holding register and sets that column's written flag. The row is fixed by the first accepted write, and writes that aim at any other row are dropped.

Programming starts when software writes a two-step unlock pair to the control register. While programming runs, a busy flag is set, reads return FFh, and control and data writes are ignored. The length of the busy period comes from a timing register, which software loads with the clock frequency in MHz times 5. The period lasts that value times 256 clock cycles. In the final busy cycle, every flagged column is copied into the captured row and every other byte of the row is left as it was. The flags and the row capture are then cleared.

The sequencer has three states. SQ_IDLE goes to SQ_ARMED on an arm write. SQ_ARMED goes to SQ_PROG on a go write, and any other control write sends it back to SQ_IDLE. SQ_PROG counts down and returns to SQ_IDLE when the count reaches zero, which is also the cycle in which it commits the row.

Top module: `eeprom_page_prog`

## Requirements
- R1: The array is reachable only while control bit 1 (map) is 1 and address bits 15..11 are all zero. When it is not reachable, reads return FFh and writes are neither latched nor programmed.
- R2: A reachable write stores its byte in the column selected by address bits 5..0 and marks that column written. The array keeps its old value until programming ends.
- R3: Programming copies only the columns marked written. The other 63-or-fewer bytes of the row keep their contents.
- R4: The row (address bits 10..6) is taken from the first accepted write. A later write to a different row is discarded.
- R5: Programming starts when a control write of 50h or 52h is followed, as the very next control write, by A0h or A2h.
- R6: Any other control value written between the arm write and the go write cancels the sequence, and the go write then has no effect.
- R7: Control readback bit 0 is busy. It is 1 starting with the cycle after the go write and stays 1 for exactly (timing register × 256) cycles.
- R8: A reachable read issued while busy returns FFh.
- R9: A reachable read issued while not busy returns the array byte one cycle after the request.
- R10: While busy, control writes (including the map bit) and column writes are ignored.
- R11: When programming ends, all written flags and the row capture are cleared. The next write may pick a new row, and the old columns are not programmed again.
- R12: After reset the control readback is 00h and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (bit 1 = map; 50h/52h arm; A0h/A2h go) |
| ctl_rdata | output | 8 | Control readback: bit 1 map, bit 0 busy, others 0 |
| tim_we | input | 1 | Timing register write strobe |
| tim_wdata | input | 8 | Timing value (MHz × 5) |
| mem_addr | input | 16 | Data address |
| mem_we | input | 1 | Data write strobe |
| mem_wdata | input | 8 | Data write byte |
| mem_re | input | 1 | Data read strobe |
| mem_rdata | output | 8 | Read byte, valid one cycle after mem_re |

## Verification
The assertions assume that the bus raises at most one strobe per cycle and that each strobe lasts a single cycle. They also assume the timing register holds a nonzero value before a go write. The stimulus drives every transaction as a one-cycle pulse from tasks on the falling edge, and it loads the timing register with 1 before each unlock pair. That keeps each busy window at 256 cycles. The only activity the bench aims inside a busy window is the set of writes and reads meant to show that such accesses are ignored or blanked.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int unsigned DW = 8;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_PROG  = 2'd2
    } seq_state_e;

    // first unlock byte: 50h or 52h
    function automatic logic is_arm(input logic [DW-1:0] v);
        return (v == 8'h50) || (v == 8'h52);
    endfunction

    // second unlock byte: A0h or A2h
    function automatic logic is_go(input logic [DW-1:0] v);
        return (v == 8'hA0) || (v == 8'hA2);
    endfunction
endpackage

// File: rtl/eep_seq_fsm.sv
module eep_seq_fsm
    import eep_pkg::*;
#(
    parameter int unsigned TIM_W    = 8,
    parameter int unsigned PRESCALE = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [DW-1:0]    ctl_wdata,
    input  logic             tim_we,
    input  logic [TIM_W-1:0] tim_wdata,
    output logic             map_o,
    output logic             busy_o,
    output logic             commit_o
);
    localparam int unsigned PRE_W = $clog2(PRESCALE);
    localparam int unsigned CNT_W = TIM_W + PRE_W;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [TIM_W-1:0] tim_q;
    logic             map_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (ctl_we && is_arm(ctl_wdata)) state_d = SQ_ARMED;
            SQ_ARMED: if (ctl_we) state_d = is_go(ctl_wdata) ? SQ_PROG : SQ_IDLE;
            SQ_PROG:  if (cnt_q == '0) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // datapath: map bit, timing register, busy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= 1'b0;
            tim_q <= '0;
            cnt_q <= '0;
        end else begin
            if (ctl_we && state_q != SQ_PROG) map_q <= ctl_wdata[1];
            if (tim_we) tim_q <= tim_wdata;
            if (state_q != SQ_PROG && state_d == SQ_PROG)
                cnt_q <= CNT_W'(tim_q) * CNT_W'(PRESCALE) - CNT_W'(1);
            else if (state_q == SQ_PROG && cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        map_o    = map_q;
        busy_o   = (state_q == SQ_PROG);
        commit_o = (state_q == SQ_PROG) && (cnt_q == '0);
    end

    AST_START_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(state_q == SQ_ARMED) && $past(ctl_we)); // R5
    AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ARMED && ctl_we && !is_go(ctl_wdata)) |=> !busy_o); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0) |=> busy_o && cnt_q == $past(cnt_q) - CNT_W'(1)); // R7
    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(map_q)); // R10
endmodule

// File: rtl/eep_col_latch.sv
module eep_col_latch
    import eep_pkg::*;
#(
    parameter int unsigned COLS  = 64,
    parameter int unsigned ROW_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [$clog2(COLS)-1:0]       col_i,
    input  logic [ROW_W-1:0]              row_i,
    input  logic [DW-1:0]                 wdata_i,
    input  logic                          busy_i,
    input  logic                          commit_i,
    output logic [COLS-1:0]               flags_o,
    output logic [COLS-1:0][DW-1:0]       data_o,
    output logic [ROW_W-1:0]              row_o
);
    logic             row_vld_q;
    logic [ROW_W-1:0] row_q;
    logic             accept;

    assign accept = wr_i && !busy_i && (!row_vld_q || row_i == row_q);
    assign row_o  = row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_vld_q <= 1'b0;
            row_q     <= '0;
        end else if (commit_i) begin
            row_vld_q <= 1'b0;
        end else if (accept && !row_vld_q) begin
            row_vld_q <= 1'b1;
            row_q     <= row_i;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_o[c] <= 1'b0;
                data_o[c]  <= '0;
            end else if (commit_i) begin
                flags_o[c] <= 1'b0;
            end else if (accept && col_i == c) begin
                flags_o[c] <= 1'b1;
                data_o[c]  <= wdata_i;
            end
        end
    end

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (flags_o == '0) && !row_vld_q); // R11
    AST_NO_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !commit_i) |=> $stable(flags_o) && $stable(data_o)); // R10
    AST_ROW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld_q && !commit_i) |=> row_vld_q && $stable(row_q)); // R4
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array
    import eep_pkg::*;
#(
    parameter int unsigned ROWS = 32,
    parameter int unsigned COLS = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  commit_i,
    input  logic [$clog2(ROWS)-1:0]               row_i,
    input  logic [COLS-1:0]                       flags_i,
    input  logic [COLS-1:0][DW-1:0]               data_i,
    input  logic                                  rd_en_i,
    input  logic                                  rd_blank_i,
    input  logic [$clog2(ROWS*COLS)-1:0]          raddr_i,
    output logic [DW-1:0]                         rdata_o
);
    localparam int unsigned BYTES = ROWS * COLS;
    localparam int unsigned COL_W = $clog2(COLS);

    logic [DW-1:0] mem [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '1;   // erased
        end else if (commit_i) begin
            for (int c = 0; c < COLS; c++)
                if (flags_i[c]) mem[{row_i, COL_W'(c)}] <= data_i[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_o <= '1;
        else if (rd_en_i) rdata_o <= rd_blank_i ? '1 : mem[raddr_i];
    end
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
    import eep_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned ARRAY_BYTES = 2048,
    parameter int unsigned PAGE_BYTES  = 64,
    parameter int unsigned TIM_W       = 8,
    parameter int unsigned PRESCALE    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DW-1:0]     ctl_wdata,
    output logic [DW-1:0]     ctl_rdata,
    input  logic              tim_we,
    input  logic [TIM_W-1:0]  tim_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  logic [DW-1:0]     mem_wdata,
    input  logic              mem_re,
    output logic [DW-1:0]     mem_rdata
);
    localparam int unsigned ROWS  = ARRAY_BYTES / PAGE_BYTES;
    localparam int unsigned COL_W = $clog2(PAGE_BYTES);
    localparam int unsigned ROW_W = $clog2(ROWS);
    localparam int unsigned ARR_W = $clog2(ARRAY_BYTES);

    logic                         map, busy, commit, hit;
    logic [PAGE_BYTES-1:0]        flags;
    logic [PAGE_BYTES-1:0][DW-1:0] col_data;
    logic [ROW_W-1:0]             row;

    assign hit       = map && (mem_addr[ADDR_W-1:ARR_W] == '0);
    assign ctl_rdata = {{(DW-2){1'b0}}, map, busy};

    eep_seq_fsm #(.TIM_W(TIM_W), .PRESCALE(PRESCALE)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tim_we(tim_we), .tim_wdata(tim_wdata),
        .map_o(map), .busy_o(busy), .commit_o(commit)
    );

    eep_col_latch #(.COLS(PAGE_BYTES), .ROW_W(ROW_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .wr_i(mem_we && hit),
        .col_i(mem_addr[COL_W-1:0]),
        .row_i(mem_addr[ARR_W-1:COL_W]),
        .wdata_i(mem_wdata),
        .busy_i(busy), .commit_i(commit),
        .flags_o(flags), .data_o(col_data), .row_o(row)
    );

    eep_cell_array #(.ROWS(ROWS), .COLS(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .row_i(row),
        .flags_i(flags), .data_i(col_data),
        .rd_en_i(mem_re), .rd_blank_i(!hit || busy),
        .raddr_i(mem_addr[ARR_W-1:0]),
        .rdata_o(mem_rdata)
    );

    AST_BUSY_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && busy) |=> mem_rdata == '1); // R8
    AST_UNMAPPED_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !map) |=> mem_rdata == '1); // R1
endmodule

// File: tb/tb_eeprom_page_prog.sv
module tb_eeprom_page_prog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        tim_we = 1'b0;
    logic [7:0]  tim_wdata = '0;
    logic [15:0] mem_addr = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_wdata = '0;
    logic        mem_re = 1'b0;
    logic [7:0]  mem_rdata;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    eeprom_page_prog dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .tim_we(tim_we), .tim_wdata(tim_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic ctl_wr(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic tim_wr(input logic [7:0] v);
        @(negedge clk); tim_we = 1'b1; tim_wdata = v;
        @(negedge clk); tim_we = 1'b0;
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk); mem_we = 1'b0;
    endtask

    // driver: issue read and push the expected byte to the scoreboard
    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); mem_re = 1'b1; mem_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); mem_re = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (ctl_rdata[0] == 1'b0) break;
        end
    endtask

    task automatic program_page();
        tim_wr(8'h01);
        ctl_wr(8'h52);
        ctl_wr(8'hA2);
        wait_idle();
    endtask

    initial begin
        // monitor: compare each read result one cycle after its request
        fork
            forever begin
                logic pend;
                @(posedge clk); pend = mem_re;
                @(negedge clk);
                if (pend) begin
                    if (exp_q.size() == 0) begin
                        compared++; mismatched++;
                        $display("FAIL R9 unexpected read result actual=%02h expected=none", mem_rdata);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front(); t = tag_q.pop_front();
                        chk(t, mem_rdata, e);
                    end
                end
            end
        join_none
        // watchdog
        fork
            begin
                repeat (150000) @(posedge clk);
                mismatched++;
                $display("FAIL watchdog expired actual=running expected=done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 control after reset", ctl_rdata, 8'h00);
        rd(16'h0040, 8'hFF, "R1 unmapped read");
        ctl_wr(8'h02);
        chk("R1 map bit set", ctl_rdata, 8'h02);
        rd(16'h07FF, 8'hFF, "R12 erased top byte");

        // first row: exact busy window
        mem_wr(16'h0040, 8'h11);
        mem_wr(16'h0045, 8'h22);
        mem_wr(16'h0083, 8'h33);     // other row: dropped
        rd(16'h0040, 8'hFF, "R2 array untouched before programming");
        tim_wr(8'h01);
        ctl_wr(8'h52);
        chk("R5 not busy after arm only", ctl_rdata, 8'h02);
        ctl_wr(8'hA2);
        chk("R7 busy after go", ctl_rdata, 8'h03);
        repeat (255) @(negedge clk);
        chk("R7 busy through last cycle", ctl_rdata, 8'h03);
        @(negedge clk);
        chk("R7 busy cleared after 256 cycles", ctl_rdata, 8'h02);
        rd(16'h0040, 8'h11, "R9 programmed byte col 0");
        rd(16'h0045, 8'h22, "R3 programmed byte col 5");
        rd(16'h0041, 8'hFF, "R3 unwritten column kept");
        rd(16'h0083, 8'hFF, "R4 other row discarded");

        // second row: new row accepted, activity while busy ignored
        mem_wr(16'h0083, 8'h33);
        tim_wr(8'h01);
        ctl_wr(8'h52);
        ctl_wr(8'hA2);
        rd(16'h0040, 8'hFF, "R8 read while busy");
        mem_wr(16'h0081, 8'h55);
        ctl_wr(8'h00);
        chk("R10 control write ignored while busy", ctl_rdata, 8'h03);
        wait_idle();
        rd(16'h0083, 8'h33, "R11 new row after clear");
        rd(16'h0080, 8'hFF, "R11 old column not reprogrammed");
        rd(16'h0085, 8'hFF, "R11 old column not reprogrammed");
        rd(16'h0081, 8'hFF, "R10 column write while busy ignored");
        rd(16'h0040, 8'h11, "R3 earlier row intact");

        // cancelled unlock
        mem_wr(16'h00C0, 8'h77);
        ctl_wr(8'h50);
        ctl_wr(8'h02);
        ctl_wr(8'hA0);
        @(negedge clk);
        chk("R6 go after cancel has no effect", ctl_rdata, 8'h00);
        ctl_wr(8'h02);
        rd(16'h00C0, 8'hFF, "R6 nothing programmed");
        ctl_wr(8'h50);
        ctl_wr(8'hA0);
        chk("R5 unlock 50h A0h starts", ctl_rdata, 8'h01);
        wait_idle();
        ctl_wr(8'h02);
        rd(16'h00C0, 8'h77, "R5 row programmed via 50h A0h");

        // unmapped and out-of-range writes
        ctl_wr(8'h00);
        mem_wr(16'h0100, 8'h99);
        ctl_wr(8'h02);
        mem_wr(16'h0800, 8'h44);
        program_page();
        rd(16'h0100, 8'hFF, "R1 write while unmapped dropped");
        rd(16'h0000, 8'hFF, "R1 out-of-range write dropped");
        rd(16'h0800, 8'hFF, "R1 out-of-range read");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R9 missing read results actual=%0d expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule